// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers eight device request lines and presents one interrupt line to a processor. It keeps a registered copy of the request levels and hides the lines that software has masked. It then picks the highest-priority line that may interrupt now and raises the interrupt output. When the processor acknowledges, the block places an 8-bit vector for the winning line on its vector output for one cycle and marks that line as in service. A handler in progress can be preempted only by a line of strictly higher priority. An end-of-interrupt strobe retires the most urgent handler in service, and lower lines can then compete again.

A second controller can be chained in through one line of this one. With cascading enabled, that line follows the cascade request input instead of its own device pin. An acknowledge won by that line does not drive a vector; it pulses a cascade acknowledge so that the chained controller supplies the vector. Software sets the vector base and the mask through a small configuration write port.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset, int_o, vec_valid_o and casc_ack_o are low, no line is in service, the vector base is 0 and every line is masked, so an active request does not raise int_o.
- R2: Request inputs are level sensitive and registered: a request present at a clock edge raises int_o after that edge, provided the line is unmasked and of higher priority than every line in service. Line 0 has the highest priority and line 7 the lowest.
- R3: A configuration write with cfg_sel_i=1 loads the mask from cfg_data_i, where bit i set blocks line i. A masked line keeps its request state, and clearing its mask bit raises int_o without a new request edge.
- R4: An acknowledge (inta_i high for one cycle) while a line is eligible sets vec_valid_o for the following cycle only, with vec_o = {base, line index}, where the line is the lowest-numbered eligible one. vec_o reads 0 while vec_valid_o is low.
- R5: While line k is in service, requests on lines k to 7 do not raise int_o, and a request on a line below k does.
- R6: An acknowledge marks the winning line as in service, so the same line held active does not raise int_o again until an end-of-interrupt.
- R7: An end-of-interrupt strobe (eoi_i high for one cycle) takes the lowest-numbered in-service line out of service, which re-enables the lines of lower priority.
- R8: An acknowledge with no eligible line (for example a request that dropped one cycle before) returns the spurious vector {base, 7} and leaves the in-service set unchanged.
- R9: A configuration write with cfg_sel_i=0 loads the base from cfg_data_i[4:0]. With cascading on, line 2 follows casc_req_i and irq_req_i[2] is ignored. An acknowledge won by line 2 pulses casc_ack_o for one cycle, keeps vec_valid_o low, and puts line 2 in service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req_i | input | 8 | Device request levels, one per line |
| casc_req_i | input | 1 | Interrupt output of the chained controller |
| inta_i | input | 1 | Processor acknowledge strobe |
| eoi_i | input | 1 | End-of-interrupt strobe |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_sel_i | input | 1 | Configuration target: 0 base, 1 mask |
| cfg_data_i | input | 8 | Configuration write data |
| int_o | output | 1 | Interrupt request to the processor |
| vec_o | output | 8 | Vector bus, valid with vec_valid_o |
| vec_valid_o | output | 1 | Vector present, one cycle after acknowledge |
| casc_ack_o | output | 1 | Acknowledge forwarded to the chained controller |

## Verification
The hardest situation to reach is a nested stack of handlers together with a request that drops one cycle before the acknowledge. That requires a chosen mix of in-service levels, pending lines and masks before the strobe arrives. Directed sequences build this up explicitly: preemption by a higher line, retiring handlers one at a time, the spurious code and the cascade acknowledge. A long random phase then drives request levels, masks, strobes and cascade requests at random and compares every cycle against a bench model of the rules.

// File: rtl/vic_pkg.sv
package vic_pkg;

    parameter int unsigned VIC_LINES = 8;
    parameter int unsigned VIC_VEC_W = 8;
    localparam int unsigned VIC_IDX_W  = $clog2(VIC_LINES);
    localparam int unsigned VIC_BASE_W = VIC_VEC_W - VIC_IDX_W;

    typedef logic [VIC_LINES-1:0]  line_vec_t;
    typedef logic [VIC_IDX_W-1:0]  line_idx_t;
    typedef logic [VIC_BASE_W-1:0] vec_base_t;
    typedef logic [VIC_VEC_W-1:0]  vector_t;

    typedef struct packed {
        logic      hit;
        line_idx_t idx;
    } pick_t;

    typedef enum logic {
        CFG_BASE = 1'b0,
        CFG_MASK = 1'b1
    } cfg_sel_e;

    // lowest-numbered set bit wins
    function automatic pick_t first_set(line_vec_t v);
        pick_t p;
        p.hit = 1'b0;
        p.idx = '0;
        for (int i = VIC_LINES - 1; i >= 0; i--) begin
            if (v[i]) begin
                p.hit = 1'b1;
                p.idx = line_idx_t'(i);
            end
        end
        return p;
    endfunction

    // lines strictly more urgent than the most urgent one in service
    function automatic line_vec_t ahead_of(line_vec_t busy);
        line_vec_t m;
        logic      seen;
        seen = 1'b0;
        for (int i = 0; i < VIC_LINES; i++) begin
            seen = seen | busy[i];
            m[i] = ~seen;
        end
        return m;
    endfunction

    function automatic line_vec_t lowest_bit(line_vec_t v);
        return v & (~v + line_vec_t'(1));
    endfunction

endpackage

// File: rtl/vic_req_latch.sv
module vic_req_latch
    import vic_pkg::*;
#(
    parameter bit          CASC_EN   = 1'b1,
    parameter int unsigned CASC_LINE = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  line_vec_t req_i,
    input  logic      casc_req_i,
    input  line_vec_t clr_i,
    output line_vec_t irr_o
);

    line_vec_t eff;
    line_vec_t irr_q;

    generate
        if (CASC_EN) begin : g_casc
            always_comb begin
                eff            = req_i;
                eff[CASC_LINE] = casc_req_i;
            end
        end else begin : g_plain
            logic unused_casc;
            assign unused_casc = casc_req_i;
            always_comb eff = req_i;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) irr_q <= '0;
        else     irr_q <= eff & ~clr_i;
    end

    assign irr_o = irr_q;

endmodule

// File: rtl/vic_cfg.sv
module vic_cfg
    import vic_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      we_i,
    input  cfg_sel_e  sel_i,
    input  vector_t   data_i,
    output vec_base_t base_o,
    output line_vec_t mask_o
);

    vec_base_t base_q;
    line_vec_t mask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            mask_q <= '1;
        end else if (we_i) begin
            case (sel_i)
                CFG_BASE: base_q <= data_i[VIC_BASE_W-1:0];
                CFG_MASK: mask_q <= line_vec_t'(data_i);
                default:  ;
            endcase
        end
    end

    assign base_o = base_q;
    assign mask_o = mask_q;

endmodule

// File: rtl/vic_resolver.sv
module vic_resolver
    import vic_pkg::*;
(
    input  line_vec_t irr_i,
    input  line_vec_t mask_i,
    input  line_vec_t isr_i,
    output pick_t     pick_o
);

    line_vec_t cand;

    always_comb begin
        cand   = irr_i & ~mask_i & ahead_of(isr_i);
        pick_o = first_set(cand);
    end

endmodule

// File: rtl/vic_service.sv
module vic_service
    import vic_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  line_vec_t set_i,
    input  logic      eoi_i,
    output line_vec_t isr_o
);

    line_vec_t isr_q;
    line_vec_t kept;

    always_comb begin
        kept = isr_q;
        if (eoi_i) kept = isr_q & ~lowest_bit(isr_q);
    end

    always_ff @(posedge clk) begin
        if (rst) isr_q <= '0;
        else     isr_q <= kept | set_i;
    end

    assign isr_o = isr_q;

endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
    import vic_pkg::*;
#(
    parameter bit          CASC_EN   = 1'b1,
    parameter int unsigned CASC_LINE = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [VIC_LINES-1:0] irq_req_i,
    input  logic                 casc_req_i,
    input  logic                 inta_i,
    input  logic                 eoi_i,
    input  logic                 cfg_we_i,
    input  logic                 cfg_sel_i,
    input  logic [VIC_VEC_W-1:0] cfg_data_i,
    output logic                 int_o,
    output logic [VIC_VEC_W-1:0] vec_o,
    output logic                 vec_valid_o,
    output logic                 casc_ack_o
);

    localparam line_idx_t SPUR_IDX = line_idx_t'(VIC_LINES - 1);
    localparam line_idx_t CASC_IDX = line_idx_t'(CASC_LINE);

    line_vec_t irr_w;
    line_vec_t mask_w;
    line_vec_t isr_w;
    line_vec_t grant_vec;
    vec_base_t base_w;
    pick_t     pick;
    logic      take;
    logic      to_casc;

    vector_t   vec_q;
    logic      vv_q;
    logic      casc_q;

    vic_cfg u_cfg (
        .clk    (clk),
        .rst    (rst),
        .we_i   (cfg_we_i),
        .sel_i  (cfg_sel_e'(cfg_sel_i)),
        .data_i (cfg_data_i),
        .base_o (base_w),
        .mask_o (mask_w)
    );

    vic_req_latch #(
        .CASC_EN   (CASC_EN),
        .CASC_LINE (CASC_LINE)
    ) u_latch (
        .clk        (clk),
        .rst        (rst),
        .req_i      (irq_req_i),
        .casc_req_i (casc_req_i),
        .clr_i      (grant_vec),
        .irr_o      (irr_w)
    );

    vic_resolver u_res (
        .irr_i  (irr_w),
        .mask_i (mask_w),
        .isr_i  (isr_w),
        .pick_o (pick)
    );

    vic_service u_svc (
        .clk   (clk),
        .rst   (rst),
        .set_i (grant_vec),
        .eoi_i (eoi_i),
        .isr_o (isr_w)
    );

    always_comb begin
        take      = inta_i & pick.hit;
        to_casc   = CASC_EN && (pick.idx == CASC_IDX);
        grant_vec = '0;
        if (take) grant_vec[pick.idx] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vec_q  <= '0;
            vv_q   <= 1'b0;
            casc_q <= 1'b0;
        end else begin
            vv_q   <= inta_i & ~(take & to_casc);
            casc_q <= take & to_casc;
            if (inta_i) vec_q <= {base_w, (take ? pick.idx : SPUR_IDX)};
        end
    end

    assign int_o       = pick.hit;
    assign vec_o       = vv_q ? vec_q : '0;
    assign vec_valid_o = vv_q;
    assign casc_ack_o  = casc_q;

endmodule

// File: rtl/vic_checker.sv
module vic_checker
    import vic_pkg::*;
(
    input logic      clk,
    input logic      rst,
    input logic      inta_i,
    input logic      eoi_i,
    input logic      int_o,
    input logic      vec_valid_o,
    input logic      casc_ack_o,
    input line_vec_t irr,
    input line_vec_t mask,
    input line_vec_t isr
);

    AST_VEC_NEEDS_ACK: assert property (@(posedge clk) disable iff (rst)
        (vec_valid_o || casc_ack_o) |-> $past(inta_i)); // R4

    AST_CASC_NO_VEC: assert property (@(posedge clk) disable iff (rst)
        casc_ack_o |-> !vec_valid_o); // R9

    AST_INT_FROM_UNMASKED: assert property (@(posedge clk) disable iff (rst)
        int_o |-> ((irr & ~mask) != '0)); // R3

    AST_ONE_NEW_SERVICE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(isr & ~$past(isr))); // R6

    AST_SERVICE_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!inta_i && !eoi_i) |=> $stable(isr)); // R6

    AST_EOI_RETIRES_ONE: assert property (@(posedge clk) disable iff (rst)
        (eoi_i && !inta_i && isr != '0) |=> ($countones(isr) + 1 == $past($countones(isr)))); // R7

endmodule

bind vec_irq_ctrl vic_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .inta_i      (inta_i),
    .eoi_i       (eoi_i),
    .int_o       (int_o),
    .vec_valid_o (vec_valid_o),
    .casc_ack_o  (casc_ack_o),
    .irr         (irr_w),
    .mask        (mask_w),
    .isr         (isr_w)
);

// File: tb/vec_irq_ctrl_test.sv
`timescale 1ns/100ps
module vec_irq_ctrl_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] irq_req_i = '0;
    logic       casc_req_i = 1'b0;
    logic       inta_i = 1'b0;
    logic       eoi_i = 1'b0;
    logic       cfg_we_i = 1'b0;
    logic       cfg_sel_i = 1'b0;
    logic [7:0] cfg_data_i = '0;
    logic       int_o;
    logic [7:0] vec_o;
    logic       vec_valid_o;
    logic       casc_ack_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // bench model state
    logic [7:0] m_irr, m_isr, m_mask;
    logic [4:0] m_base;
    logic       e_int, e_vv, e_casc;
    logic [7:0] e_vec;

    always #2.5 clk = ~clk;

    vec_irq_ctrl uut (
        .clk(clk), .rst(rst), .irq_req_i(irq_req_i), .casc_req_i(casc_req_i),
        .inta_i(inta_i), .eoi_i(eoi_i), .cfg_we_i(cfg_we_i), .cfg_sel_i(cfg_sel_i),
        .cfg_data_i(cfg_data_i), .int_o(int_o), .vec_o(vec_o),
        .vec_valid_o(vec_valid_o), .casc_ack_o(casc_ack_o)
    );

    function automatic int top_line(logic [7:0] v);
        for (int i = 0; i < 8; i++) if (v[i]) return i;
        return -1;
    endfunction

    function automatic logic [7:0] allowed(logic [7:0] busy);
        int k;
        logic [7:0] r;
        k = top_line(busy);
        if (k < 0) return 8'hFF;
        r = '0;
        for (int i = 0; i < 8; i++) if (i < k) r[i] = 1'b1;
        return r;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_irr = '0; m_isr = '0; m_mask = 8'hFF; m_base = '0;
        e_int = 1'b0; e_vv = 1'b0; e_casc = 1'b0; e_vec = '0;
    endtask

    // one clock: model update at the edge, compare at the following negedge
    task automatic step();
        logic [7:0] eff, clr, setb, cand;
        int w;
        @(posedge clk);
        eff = irq_req_i;
        eff[2] = casc_req_i;
        cand = m_irr & ~m_mask & allowed(m_isr);
        w = top_line(cand);
        clr = '0; setb = '0;
        e_vv = 1'b0; e_casc = 1'b0; e_vec = '0;
        if (rst) begin
            model_reset();
        end else begin
            if (inta_i) begin
                if (w >= 0) begin
                    setb[w] = 1'b1; clr[w] = 1'b1;
                    if (w == 2) e_casc = 1'b1;
                    else begin e_vv = 1'b1; e_vec = {m_base, 3'(w)}; end
                end else begin
                    e_vv = 1'b1; e_vec = {m_base, 3'd7};
                end
            end
            if (eoi_i && m_isr != 0) m_isr[top_line(m_isr)] = 1'b0;
            m_isr = m_isr | setb;
            m_irr = eff & ~clr;
            if (cfg_we_i) begin
                if (cfg_sel_i) m_mask = cfg_data_i;
                else m_base = cfg_data_i[4:0];
            end
            e_int = |(m_irr & ~m_mask & allowed(m_isr));
        end
        @(negedge clk);
        chk("R2 int_o", int_o, e_int);
        chk("R4 vec_valid_o", vec_valid_o, e_vv);
        chk("R4 vec_o", vec_o, e_vec);
        chk("R9 casc_ack_o", casc_ack_o, e_casc);
        inta_i = 1'b0; eoi_i = 1'b0; cfg_we_i = 1'b0;
    endtask

    task automatic cfg_write(logic sel, logic [7:0] d);
        cfg_we_i = 1'b1; cfg_sel_i = sel; cfg_data_i = d;
        step();
    endtask

    initial begin
        int unsigned seed;
        seed = $urandom(32'd4242);
        model_reset();
        @(negedge clk);
        repeat (3) step();
        rst = 1'b0;
        step();
        // R1: idle after reset
        chk("R1 int_o", int_o, 0);
        chk("R1 vec_valid_o", vec_valid_o, 0);
        chk("R1 casc_ack_o", casc_ack_o, 0);
        irq_req_i = 8'h08;
        step(); step();
        chk("R1 masked at reset", int_o, 0);
        // R3: unmask keeps pending line 3
        cfg_write(1'b1, 8'h00);
        chk("R3 unmask raises int", int_o, 1);
        // R9 base field: base 0x1A
        cfg_write(1'b0, 8'h1A);
        inta_i = 1'b1; step();
        chk("R4 vector line3", vec_o, 8'hD3);
        chk("R6 line3 in service", int_o, 0);
        // R5 nesting
        irq_req_i = 8'h28; step();
        chk("R5 lower line held", int_o, 0);
        irq_req_i = 8'h2A; step();
        chk("R5 higher line preempts", int_o, 1);
        inta_i = 1'b1; step();
        chk("R4 vector line1", vec_o, 8'hD1);
        // R7 end of interrupt
        irq_req_i = 8'h28; eoi_i = 1'b1; step();
        chk("R7 retire line1 only", int_o, 0);
        eoi_i = 1'b1; step();
        chk("R7 retire line3", int_o, 1);
        // R8 spurious
        irq_req_i = 8'h00; step();
        inta_i = 1'b1; step();
        chk("R8 spurious vector", vec_o, 8'hD7);
        irq_req_i = 8'h40; step();
        chk("R8 no service change", int_o, 1);
        irq_req_i = 8'h00; step();
        // R9 cascade
        irq_req_i = 8'h04; step();
        chk("R9 pin 2 ignored", int_o, 0);
        casc_req_i = 1'b1; step();
        chk("R9 cascade request", int_o, 1);
        inta_i = 1'b1; step();
        chk("R9 cascade ack", casc_ack_o, 1);
        chk("R9 no vector", vec_valid_o, 0);
        casc_req_i = 1'b0; irq_req_i = 8'h00; eoi_i = 1'b1; step();
        // random phase
        for (int n = 0; n < 4000; n++) begin
            if ($urandom % 6 == 0) irq_req_i = 8'($urandom);
            if ($urandom % 8 == 0) casc_req_i = 1'($urandom);
            inta_i = (int_o && ($urandom % 3 == 0)) || ($urandom % 40 == 0);
            eoi_i = ($urandom % 7 == 0);
            if ($urandom % 60 == 0) begin
                cfg_we_i = 1'b1; cfg_sel_i = 1'($urandom);
                cfg_data_i = 8'($urandom & $urandom);
            end
            step();
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule